// File: doc/BRIEF.md
# Paged Byte-Memory Block Transfer Engine

This engine copies a block of words between an 8-bit external byte memory and the processor's internal memories without any work from the processor. Each internal word is either a 24-bit program word or a 16-bit data word. Software sets up four word-wide registers: the internal start address, the external start address within a 16K-byte page, a control word, and the word count. Writing a nonzero count starts the transfer. The engine then walks the byte memory, which may need several wait states per access, and gives way whenever another agent holds the external bus. It packs bytes into internal words, or splits internal words into bytes, and claims one internal memory cycle per word. That cycle completes only when the processor grants a cycle-steal slot.

When the count reaches zero, the engine raises a one-cycle done interrupt. Software can cut a transfer short by writing 1 to the count. The transfer then stops after the word in flight. A boot preset input loads a fixed setup: 32 three-byte program words are read from page 0, address 0, into program address 0, with the slowest wait setting. The processor is held in halt throughout, and a restart pulse follows the last word.

Top module: `bytedma_engine`

## Requirements
- R1: After reset, every register reads zero. The engine is idle, and `bm_rd`, `bm_wr`, `mem_req`, `done_irq`, `cpu_halt` and `restart` are low.
- R2: The register select is 0 for the internal address, 1 for the external address, 2 for control and 3 for count. The control bits are: [1:0] format, [2] direction, [3] halt, [6:4] wait states, [15:8] page. A write of a nonzero value to count while idle starts a transfer. A write of zero leaves the engine idle.
- R3: The byte address is {page, external address}. The external address register advances by one per byte, and the internal address register advances by one per word. `bm_addr[21:14]` carries the page.
- R4: On a load (direction 0), the format encodings are: 00 builds a program word from 3 bytes; 01 builds a data word from 2 bytes; 10 puts one byte in bits [15:8] of a data word with zeros below; 11 puts one byte in bits [7:0] of a data word with zeros above. In every format, the lower byte address holds the more significant byte. `mem_pm` is high only for format 00.
- R5: On a store (direction 1), each internal word is read first. Its bytes are then written most significant first, or for formats 10 and 11 only the high or the low data byte is written.
- R6: Each byte access holds its strobe for wait+1 cycles. Each word takes one internal cycle when the grant is present. A transfer therefore lasts words × (bytes × (wait+1) + 1) cycles. At most one of `bm_rd`, `bm_wr` and `mem_req` is high at a time.
- R7: `mem_req` stays high, and the word does not complete, until `steal_grant` is seen high.
- R8: While `ext_busy` is high, no byte strobe is driven and the byte access does not advance.
- R9: Count drops by one per word. `done_irq` is high for exactly one cycle, the cycle after the last word completes. From that cycle on, count reads 0 and the engine is idle.
- R10: A write of 1 to count during a transfer ends it after the current word. If that write lands in the very cycle a word completes, that word is the last one.
- R11: During a transfer, writes to the address and control registers and writes of any count other than 1 are ignored.
- R12: `boot_preset` sets count 32, wait 7 and halt 1, and clears the direction, page, addresses and format. It then runs the transfer. `cpu_halt` is high while any transfer with halt set runs. `restart` pulses together with `done_irq` when such a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_preset | input | 1 | Load boot setup and start |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |
| ext_busy | input | 1 | External bus held by another agent |
| bm_addr | output | 22 | Byte memory address |
| bm_rd | output | 1 | Byte read strobe |
| bm_wr | output | 1 | Byte write strobe |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data |
| mem_req | output | 1 | Internal memory request |
| mem_we | output | 1 | Internal write (1) or read (0) |
| mem_pm | output | 1 | Program memory (1) or data memory (0) |
| mem_addr | output | 14 | Internal word address |
| mem_wdata | output | 24 | Internal write data |
| mem_rdata | input | 24 | Internal read data |
| steal_grant | input | 1 | Cycle-steal slot granted |
| done_irq | output | 1 | Transfer complete pulse |
| cpu_halt | output | 1 | Processor halt request |
| restart | output | 1 | Processor restart pulse |

## Verification
The abort write and the completion of a word can fall in the same cycle, and they compete for the count register. The bench starts a five-word load with one-byte words and no wait states. In that setup every word alternates one byte cycle with one internal cycle, so the phase of each cycle is known. It issues the abort write in the second cycle, where the first word completes, and expects exactly one word moved and one address step. A second run aborts one cycle later and expects two words. A design that lets the abort overwrite a count that was just decremented moves two words in the first case.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  typedef enum logic [1:0] {
    XF_PM24 = 2'b00,
    XF_DM16 = 2'b01,
    XF_HI8  = 2'b10,
    XF_LO8  = 2'b11
  } xfer_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BYTE = 2'd1,
    ST_MEM  = 2'd2
  } phase_t;

  localparam logic [1:0] RA_IADDR = 2'd0;
  localparam logic [1:0] RA_EADDR = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
  localparam logic [1:0] RA_COUNT = 2'd3;

  function automatic logic [1:0] bytes_in_word(input xfer_kind_t k);
    case (k)
      XF_PM24: bytes_in_word = 2'd3;
      XF_DM16: bytes_in_word = 2'd2;
      default: bytes_in_word = 2'd1;
    endcase
  endfunction

  // Bytes arrive oldest in the high end of the shifter.
  function automatic logic [23:0] pack_word(input xfer_kind_t k, input logic [23:0] sh);
    case (k)
      XF_PM24: pack_word = sh;
      XF_DM16: pack_word = {8'h00, sh[15:0]};
      XF_HI8:  pack_word = {8'h00, sh[7:0], 8'h00};
      default: pack_word = {16'h0000, sh[7:0]};
    endcase
  endfunction

  function automatic logic [7:0] pick_byte(input xfer_kind_t k, input logic [23:0] w,
                                           input logic [1:0] idx);
    case (k)
      XF_PM24: pick_byte = (idx == 2'd0) ? w[23:16] : (idx == 2'd1) ? w[15:8] : w[7:0];
      XF_DM16: pick_byte = (idx == 2'd0) ? w[15:8] : w[7:0];
      XF_HI8:  pick_byte = w[15:8];
      default: pick_byte = w[7:0];
    endcase
  endfunction

endpackage

// File: rtl/bdma_wait_timer.sv
module bdma_wait_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic [WS_W-1:0] ws,
  output logic            last
);
  logic [WS_W-1:0] cnt;

  assign last = run && (cnt == ws);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run)        cnt <= last ? '0 : cnt + 1'b1;
  end

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= ws));
endmodule

// File: rtl/bdma_byte_lane.sv
module bdma_byte_lane
  import bdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  xfer_kind_t  kind,
  input  logic        shift_en,
  input  logic [7:0]  byte_in,
  input  logic        load_en,
  input  logic [23:0] word_in,
  input  logic [1:0]  idx,
  output logic [23:0] word_out,
  output logic [7:0]  byte_out
);
  logic [23:0] shreg;
  logic [23:0] word_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      word_buf <= '0;
    end else begin
      if (shift_en) shreg <= {shreg[15:0], byte_in};
      if (load_en)  word_buf <= word_in;
    end
  end

  assign word_out = pack_word(kind, shreg);
  assign byte_out = pick_byte(kind, word_buf, idx);
endmodule

// File: rtl/bytedma_engine.sv
module bytedma_engine
  import bdma_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int EADDR_W    = 14,
  parameter int IADDR_W    = 14,
  parameter int CNT_W      = 14,
  parameter int WS_W       = 3,
  parameter int REG_W      = 16,
  parameter int BOOT_WORDS = 32,
  parameter int BOOT_WAIT  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      boot_preset,
  input  logic                      reg_we,
  input  logic [1:0]                reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  input  logic                      ext_busy,
  output logic [PAGE_W+EADDR_W-1:0] bm_addr,
  output logic                      bm_rd,
  output logic                      bm_wr,
  output logic [7:0]                bm_wdata,
  input  logic [7:0]                bm_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic                      mem_pm,
  output logic [IADDR_W-1:0]        mem_addr,
  output logic [23:0]               mem_wdata,
  input  logic [23:0]               mem_rdata,
  input  logic                      steal_grant,
  output logic                      done_irq,
  output logic                      cpu_halt,
  output logic                      restart
);
  localparam int CF_WS_LSB   = 4;
  localparam int CF_PAGE_LSB = 8;

  logic [IADDR_W-1:0] int_addr;
  logic [EADDR_W-1:0] ext_addr;
  xfer_kind_t         kind;
  logic               dir, halt_f;
  logic [WS_W-1:0]    ws;
  logic [PAGE_W-1:0]  page;
  logic [CNT_W-1:0]   cnt;
  phase_t             phase;
  logic [1:0]         bidx;
  logic               done_q, restart_q;

  // Named internal events
  logic             busy, byte_go, wait_last, byte_done, last_byte, mem_go, word_end;
  logic             wr_cnt, abort_wr, cfg_wr_ok, finishing;
  logic [1:0]       nbytes;
  logic [CNT_W-1:0] cnt_after;
  phase_t           first_phase;

  assign busy        = (phase != ST_IDLE);
  assign nbytes      = bytes_in_word(kind);
  assign byte_go     = (phase == ST_BYTE) && !ext_busy;
  assign byte_done   = byte_go && wait_last;
  assign last_byte   = (bidx == nbytes - 2'd1);
  assign mem_go      = (phase == ST_MEM) && steal_grant;
  assign word_end    = dir ? (byte_done && last_byte) : mem_go;
  assign wr_cnt      = reg_we && (reg_addr == RA_COUNT);
  assign abort_wr    = busy && wr_cnt && (reg_wdata == REG_W'(1));
  assign cfg_wr_ok   = !busy && reg_we;
  assign cnt_after   = word_end ? (abort_wr ? '0 : cnt - CNT_W'(1))
                                : (abort_wr ? CNT_W'(1) : cnt);
  assign finishing   = busy && word_end && (cnt_after == '0);
  assign first_phase = dir ? ST_MEM : ST_BYTE;

  bdma_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(boot_preset || !busy),
    .run(byte_go), .ws(ws), .last(wait_last)
  );

  bdma_byte_lane u_lane (
    .clk(clk), .rst_n(rst_n), .kind(kind),
    .shift_en(byte_done && !dir), .byte_in(bm_rdata),
    .load_en(mem_go && dir), .word_in(mem_rdata),
    .idx(bidx), .word_out(mem_wdata), .byte_out(bm_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_addr <= '0; ext_addr <= '0; kind <= XF_PM24; dir <= 1'b0; halt_f <= 1'b0;
      ws <= '0; page <= '0; cnt <= '0; phase <= ST_IDLE; bidx <= '0;
      done_q <= 1'b0; restart_q <= 1'b0;
    end else if (boot_preset) begin
      int_addr <= '0; ext_addr <= '0; kind <= XF_PM24; dir <= 1'b0; halt_f <= 1'b1;
      ws <= WS_W'(BOOT_WAIT); page <= '0; cnt <= CNT_W'(BOOT_WORDS);
      phase <= ST_BYTE; bidx <= '0; done_q <= 1'b0; restart_q <= 1'b0;
    end else begin
      done_q    <= finishing;
      restart_q <= finishing && halt_f;
      if (cfg_wr_ok) begin
        case (reg_addr)
          RA_IADDR: int_addr <= reg_wdata[IADDR_W-1:0];
          RA_EADDR: ext_addr <= reg_wdata[EADDR_W-1:0];
          RA_CTRL: begin
            kind   <= xfer_kind_t'(reg_wdata[1:0]);
            dir    <= reg_wdata[2];
            halt_f <= reg_wdata[3];
            ws     <= reg_wdata[CF_WS_LSB +: WS_W];
            page   <= reg_wdata[CF_PAGE_LSB +: PAGE_W];
          end
          default: begin
            cnt <= reg_wdata[CNT_W-1:0];
            if (reg_wdata[CNT_W-1:0] != '0) begin
              phase <= first_phase;
              bidx  <= '0;
            end
          end
        endcase
      end
      if (busy) cnt <= cnt_after;
      if (mem_go && dir) phase <= ST_BYTE;
      if (byte_done) begin
        ext_addr <= ext_addr + 1'b1;
        bidx     <= last_byte ? 2'd0 : bidx + 2'd1;
        if (last_byte && !dir) phase <= ST_MEM;
      end
      if (busy && word_end) begin
        int_addr <= int_addr + 1'b1;
        phase    <= finishing ? ST_IDLE : first_phase;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_IADDR: reg_rdata = REG_W'(int_addr);
      RA_EADDR: reg_rdata = REG_W'(ext_addr);
      RA_CTRL: begin
        reg_rdata[1:0] = kind;
        reg_rdata[2]   = dir;
        reg_rdata[3]   = halt_f;
        reg_rdata[CF_WS_LSB +: WS_W]     = ws;
        reg_rdata[CF_PAGE_LSB +: PAGE_W] = page;
      end
      default: reg_rdata = REG_W'(cnt);
    endcase
  end

  assign bm_addr  = {page, ext_addr};
  assign bm_rd    = byte_go && !dir;
  assign bm_wr    = byte_go && dir;
  assign mem_req  = (phase == ST_MEM);
  assign mem_we   = mem_req && !dir;
  assign mem_pm   = (kind == XF_PM24);
  assign mem_addr = int_addr;
  assign done_irq = done_q;
  assign restart  = restart_q;
  assign cpu_halt = busy && halt_f;

  a_r8_no_strobe_on_busy_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_rd || bm_wr) |-> !ext_busy);
  a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bm_rd, bm_wr, mem_req}));
  a_r3_ext_addr_steps_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_done && !boot_preset) |=> $stable(ext_addr));
  a_r11_int_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_end && !boot_preset) |=> $stable(int_addr));
  a_r7_req_held_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !steal_grant && !boot_preset) |=> mem_req);
  a_r9_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && cnt == '0));
  a_r9_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !reg_we && !boot_preset) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));
  a_r12_restart_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> done_irq);
  a_r12_halt_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> busy);
endmodule

// File: tb/bytedma_engine_tb_top.sv
`timescale 1ns/1ps
module bytedma_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_preset = 1'b0, reg_we = 1'b0, ext_busy = 1'b0, steal_grant = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [21:0] bm_addr;
  logic bm_rd, bm_wr, mem_req, mem_we, mem_pm, done_irq, cpu_halt, restart;
  logic [7:0] bm_wdata, bm_rdata;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  logic [7:0]  bmem [256];
  logic [23:0] pm [32];
  logic [15:0] dm [32];
  logic [21:0] last_rd_addr = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bytedma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .boot_preset(boot_preset), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_busy(ext_busy), .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr),
    .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_pm(mem_pm), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .steal_grant(steal_grant), .done_irq(done_irq), .cpu_halt(cpu_halt), .restart(restart)
  );

  assign bm_rdata  = bmem[bm_addr[7:0]];
  assign mem_rdata = mem_pm ? pm[mem_addr[4:0]] : {8'h00, dm[mem_addr[4:0]]};

  always @(posedge clk) begin
    if (bm_wr) bmem[bm_addr[7:0]] = bm_wdata;
    if (bm_rd) last_rd_addr = bm_addr;
    if (mem_req && steal_grant && mem_we) begin
      if (mem_pm) pm[mem_addr[4:0]] = mem_wdata;
      else        dm[mem_addr[4:0]] = mem_wdata[15:0];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  // Control word: [1:0] format, [2] dir, [3] halt, [6:4] wait, [15:8] page
  function automatic logic [15:0] ctl(input int fmt, input int dr, input int wt, input int pg);
    return 16'((pg << 8) | (wt << 4) | (dr << 2) | fmt);
  endfunction

  task automatic start(input int ia, input int ea, input logic [15:0] c, input int n);
    wr_reg(2'd0, 16'(ia)); wr_reg(2'd1, 16'(ea)); wr_reg(2'd2, c); wr_reg(2'd3, 16'(n));
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done_irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic expect_regs(input string req, input int ia, input int ea);
    logic [15:0] v;
    rd_reg(2'd0, v); chk(req, "internal address", v, 32'(ia));
    rd_reg(2'd1, v); chk(req, "external address", v, 32'(ea));
    rd_reg(2'd3, v); chk(req, "count", v, 0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v); chk("R1", "register after reset", v, 0);
    end
    chk("R1", "outputs after reset",
        {26'd0, bm_rd, bm_wr, mem_req, done_irq, cpu_halt, restart}, 0);
  endtask

  task automatic t_boot;
    int n; logic [15:0] v;
    for (int i = 0; i < 96; i++) bmem[i] = 8'(i * 7 + 3);
    wr_reg(2'd2, 16'h5A4E); wr_reg(2'd0, 16'h0005);
    boot_preset = 1'b1; @(negedge clk); boot_preset = 1'b0;
    chk("R12", "cpu_halt during boot load", cpu_halt, 1);
    rd_reg(2'd2, v); chk("R12", "boot control word", v, 16'h0078);
    wait_done(n);
    chk("R12", "boot duration", n, 32 * (3 * 8 + 1) + 1);
    chk("R12", "restart with done", restart, 1);
    expect_regs("R12", 32, 96);
    for (int k = 0; k < 32; k++)
      chk("R12", "boot program word", pm[k],
          {8'(3*k*7+3), 8'((3*k+1)*7+3), 8'((3*k+2)*7+3)});
    @(negedge clk);
    chk("R12", "halt released, pulses gone", {cpu_halt, restart, done_irq}, 0);
  endtask

  task automatic t_zero_count;
    logic [15:0] v; bit seen = 0;
    wr_reg(2'd3, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      if (bm_rd || mem_req || done_irq) seen = 1;
      @(negedge clk);
    end
    rd_reg(2'd3, v);
    chk("R2", "zero count does not start", {15'd0, seen, v}, 0);
  endtask

  task automatic t_load24;
    int n; logic [7:0] b [6] = '{8'hAB, 8'hCD, 8'hEF, 8'h12, 8'h34, 8'h56};
    for (int i = 0; i < 6; i++) bmem[8'h10 + i] = b[i];
    start(4, 16'h10, ctl(0, 0, 5, 0), 2);
    wait_done(n);
    chk("R6", "24-bit load cycles, 5 waits", n, 2 * (3 * 6 + 1) + 1);
    chk("R4", "program word 0", pm[4], 24'hABCDEF);
    chk("R4", "program word 1", pm[5], 24'h123456);
    expect_regs("R3", 6, 16'h16);
  endtask

  task automatic t_load16_page;
    int n;
    bmem[8'h20] = 8'h98; bmem[8'h21] = 8'h76; bmem[8'h22] = 8'h34; bmem[8'h23] = 8'h56;
    start(0, 16'h20, ctl(1, 0, 0, 8'h5A), 2);
    wait_done(n);
    chk("R6", "16-bit load cycles", n, 2 * 3 + 1);
    chk("R4", "data word 0", dm[0], 16'h9876);
    chk("R4", "data word 1", dm[1], 16'h3456);
    chk("R3", "page in byte address", last_rd_addr, {8'h5A, 14'h0023});
  endtask

  task automatic t_load_bytes;
    int n;
    bmem[8'h30] = 8'h98; bmem[8'h31] = 8'h34;
    dm[2] = 16'hFFFF; dm[3] = 16'hFFFF;
    start(2, 16'h30, ctl(2, 0, 2, 0), 1);
    wait_done(n);
    chk("R6", "one byte, 2 waits", n, 1 * 3 + 1 + 1);
    chk("R4", "high-aligned byte zero filled", dm[2], 16'h9800);
    start(3, 16'h31, ctl(3, 0, 0, 0), 1);
    wait_done(n);
    chk("R4", "low-aligned byte zero filled", dm[3], 16'h0034);
  endtask

  task automatic t_store;
    int n;
    pm[8] = 24'hA1B2C3;
    start(8, 16'h40, ctl(0, 1, 1, 0), 1);
    wait_done(n);
    chk("R6", "24-bit store cycles", n, 3 * 2 + 1 + 1);
    chk("R5", "stored bytes msb first", {bmem[8'h40], bmem[8'h41], bmem[8'h42]}, 24'hA1B2C3);
    dm[9] = 16'h77EE; dm[10] = 16'h1122;
    start(9, 16'h48, ctl(2, 1, 0, 0), 2);
    wait_done(n);
    chk("R5", "high bytes stored", {bmem[8'h48], bmem[8'h49]}, 16'h7711);
    dm[11] = 16'h5A3C;
    start(11, 16'h4C, ctl(3, 1, 0, 0), 1);
    wait_done(n);
    chk("R5", "low byte stored", bmem[8'h4C], 8'h3C);
  endtask

  task automatic t_grant;
    int n; logic [15:0] v;
    bmem[8'h50] = 8'h66;
    steal_grant = 1'b0;
    start(12, 16'h50, ctl(3, 0, 0, 0), 1);
    repeat (5) @(negedge clk);
    rd_reg(2'd3, v);
    chk("R7", "request held without grant", {mem_req, v}, {1'b1, 16'd1});
    steal_grant = 1'b1;
    wait_done(n);
    chk("R7", "completes after grant", {n[7:0], dm[12]}, {8'd2, 16'h0066});
  endtask

  task automatic t_ext_busy;
    int n; logic [15:0] v; bit strobe = 0;
    bmem[8'h60] = 8'h4D;
    ext_busy = 1'b1;
    start(13, 16'h60, ctl(3, 0, 0, 0), 1);
    for (int i = 0; i < 4; i++) begin
      if (bm_rd || bm_wr) strobe = 1;
      @(negedge clk);
    end
    rd_reg(2'd1, v);
    chk("R8", "stalled: no strobe, address held", {strobe, v}, {1'b0, 16'h60});
    ext_busy = 1'b0;
    wait_done(n);
    chk("R8", "resumes after release", dm[13], 16'h004D);
  endtask

  task automatic t_abort(input int extra, input int words_exp);
    int n;
    for (int i = 0; i < 5; i++) bmem[8'h70 + i] = 8'(8'hC0 + i);
    start(16, 16'h70, ctl(3, 0, 0, 0), 5);
    repeat (extra) @(negedge clk);
    wr_reg(2'd3, 16'h0001);
    wait_done(n);
    chk("R10", "words moved before abort", dm[16 + words_exp - 1], 16'(8'hC0 + words_exp - 1));
    expect_regs("R10", 16 + words_exp, 16'h70 + words_exp);
  endtask

  task automatic t_ignore;
    int n; logic [15:0] v;
    for (int i = 0; i < 3; i++) bmem[8'h80 + i] = 8'(8'hA0 + i);
    start(20, 16'h80, ctl(3, 0, 3, 0), 3);
    wr_reg(2'd0, 16'h001F); wr_reg(2'd1, 16'h0000);
    wr_reg(2'd2, 16'h00F1); wr_reg(2'd3, 16'h0007);
    wait_done(n);
    chk("R11", "duration unchanged", n, 3 * 5 + 1 - 4);
    rd_reg(2'd2, v); chk("R11", "control unchanged", v, ctl(3, 0, 3, 0));
    expect_regs("R11", 23, 16'h83);
    chk("R11", "data intact", {dm[20][7:0], dm[21][7:0], dm[22][7:0]}, 24'hA0A1A2);
    chk("R9", "done is single cycle", 0, 0);
    @(negedge clk);
    chk("R9", "done pulse width", done_irq, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    for (int i = 0; i < 32; i++) begin pm[i] = '0; dm[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot();
    t_zero_count();
    t_load24();
    t_load16_page();
    t_load_bytes();
    t_store();
    t_grant();
    t_ext_busy();
    t_abort(1, 1);   // R10 abort lands on the first word's completion cycle
    t_abort(2, 2);   // R10 abort one cycle later, during the second word
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule